// File: doc/BRIEF.md
# Fixed Cosine Coefficient Multiplier

This unit scales a signed input sample by one of the fourteen constant cosine weights of an 8-point DCT (plus and minus c1 through c7). It contains no general multiplier. Each product is a sum of hard-wired shifted copies of a few small odd multiples of the sample (1x, 3x, 5x, 7x). These odd multiples are built once and shared by every coefficient. The shifted terms are laid out as canonic signed digit groups, so that no coefficient needs more than three terms.

The pipeline has three stages with one add/subtract level in each. Stage one forms the shared odd multiples. Stage two picks, shifts and sign-corrects the terms of the selected coefficient and adds two of them. Stage three adds the last term. One operand can enter on every clock. The result keeps all twelve fractional coefficient bits, so the output integer equals the sample times the 12-bit coefficient integer. A transform engine feeds the samples and adds up the products outside this block.

Top module: `csd_coef_mult`

## Requirements
- R1: Index k in 1..7 selects the 12-bit fractional weight round(4096*0.5*cos(k*pi/16)). These are 2009, 1892, 1703, 1448, 1138, 784 and 400 for k = 1..7.
- R2: When the sign flag is 0 and the index is 1..7, `out_prod` equals the exact two's-complement product `in_x` times the weight of R1, with no rounding.
- R3: When the sign flag is 1, `out_prod` equals the negation of the R2 product for the same sample and index.
- R4: Index 0 selects no weight. Its product is 0 for either sign flag and for any sample.
- R5: `out_vld` rises exactly three clock cycles after the cycle in which `in_vld` was sampled high, and it carries that operand's product.
- R6: An operand is accepted on every cycle with `in_vld` high. A back-to-back stream gives one result per cycle, in the order the operands arrived.
- R7: On cycles without a new result, `out_prod` keeps its last value. Inputs presented with `in_vld` low have no effect on it.
- R8: While `rst` is high, and on the first cycle after it, `out_vld` is 0 and `out_prod` is 0.
- R9: Every product lies within plus or minus 2009*2^(XW-1) (514304 for a 9-bit sample). The extreme cases are the most negative sample times plus and minus c1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand strobe |
| in_x | input | XW (9) | Signed sample |
| in_idx | input | 3 | Coefficient index, 0 means none, 1..7 select c1..c7 |
| in_neg | input | 1 | 1 selects the negated coefficient |
| out_vld | output | 1 | Result strobe |
| out_prod | output | XW+12 (21) | Signed product, 12 fractional bits |

## Verification
The embedded properties check on every cycle that the strobe has a fixed three-cycle delay, that the output is held while no result arrives, that index 0 yields zero, and that every result stays inside the R9 bound. Whether each of the fourteen hard-wired digit trees gives the correct weight can only be shown by the bench. It sweeps every signed sample through every index and sign in one continuous stream and compares each result with a product computed by plain integer arithmetic. Directed vectors add the extreme samples, and a check of the output with the strobe low covers R7.

// File: rtl/csd_pkg.sv
package csd_pkg;

  localparam int COEF_FRAC = 12;   // fractional bits of every weight
  localparam int NTERM     = 3;    // maximum terms per weight
  localparam int SHW       = 4;    // width of a term shift amount
  localparam int IDXW      = 3;    // coefficient index width

  typedef enum logic [1:0] {
    BASE_1 = 2'd0,
    BASE_3 = 2'd1,
    BASE_5 = 2'd2,
    BASE_7 = 2'd3
  } base_e;

  typedef struct packed {
    logic             used;
    logic             minus;
    base_e            base;
    logic [SHW-1:0]   sh;
  } term_t;

  function automatic term_t mk(input logic minus, input base_e b, input int sh);
    term_t t;
    t.used  = 1'b1;
    t.minus = minus;
    t.base  = b;
    t.sh    = SHW'(sh);
    return t;
  endfunction

  // Hard-wired signed-digit groups for each weight, built on shared odd multiples.
  function automatic term_t coef_term(input logic [IDXW-1:0] idx, input int slot);
    term_t t;
    t = '0;
    unique case (idx)
      3'd1: case (slot) 0: t = mk(1'b0, BASE_1, 11); 1: t = mk(1'b1, BASE_5, 3); default: t = mk(1'b0, BASE_1, 0); endcase
      3'd2: case (slot) 0: t = mk(1'b0, BASE_1, 11); 1: t = mk(1'b1, BASE_5, 5); default: t = mk(1'b0, BASE_1, 2); endcase
      3'd3: case (slot) 0: t = mk(1'b0, BASE_3, 9);  1: t = mk(1'b0, BASE_5, 5); default: t = mk(1'b0, BASE_7, 0); endcase
      3'd4: case (slot) 0: t = mk(1'b0, BASE_3, 9);  1: t = mk(1'b1, BASE_1, 6); default: t = mk(1'b1, BASE_3, 3); endcase
      3'd5: case (slot) 0: t = mk(1'b0, BASE_1, 10); 1: t = mk(1'b0, BASE_7, 4); default: t = mk(1'b0, BASE_1, 1); endcase
      3'd6: case (slot) 0: t = mk(1'b0, BASE_3, 8);  1: t = mk(1'b0, BASE_1, 4); default: t = '0; endcase
      3'd7: case (slot) 0: t = mk(1'b0, BASE_5, 6);  1: t = mk(1'b0, BASE_5, 4); default: t = '0; endcase
      default: t = '0;
    endcase
    return t;
  endfunction

  function automatic int base_factor(input base_e b);
    case (b)
      BASE_1:  return 1;
      BASE_3:  return 3;
      BASE_5:  return 5;
      default: return 7;
    endcase
  endfunction

  // Integer weight rebuilt from its terms (used for bounds in the checks).
  function automatic int coef_value(input logic [IDXW-1:0] idx);
    int acc;
    term_t t;
    acc = 0;
    for (int s = 0; s < NTERM; s++) begin
      t = coef_term(idx, s);
      if (t.used)
        acc += (t.minus ? -1 : 1) * (base_factor(t.base) << t.sh);
    end
    return acc;
  endfunction

endpackage

// File: rtl/csd_base_stage.sv
module csd_base_stage
  import csd_pkg::*;
#(
  parameter int XW = 9,
  localparam int BW = XW + 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_vld,
  input  logic signed [XW-1:0]   in_x,
  input  logic [IDXW-1:0]        in_idx,
  input  logic                   in_neg,
  output logic                   s1_vld,
  output logic [IDXW-1:0]        s1_idx,
  output logic                   s1_neg,
  output logic signed [BW-1:0]   s1_b1,
  output logic signed [BW-1:0]   s1_b3,
  output logic signed [BW-1:0]   s1_b5,
  output logic signed [BW-1:0]   s1_b7
);

  // Sign extension happens before any shift.
  logic signed [BW-1:0] x_ext;
  logic signed [BW-1:0] b3_c, b5_c, b7_c;

  always_comb begin
    x_ext = {{(BW-XW){in_x[XW-1]}}, in_x};
    b3_c  = (x_ext <<< 1) + x_ext;
    b5_c  = (x_ext <<< 2) + x_ext;
    b7_c  = (x_ext <<< 3) - x_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_idx <= '0;
      s1_neg <= 1'b0;
      s1_b1  <= '0;
      s1_b3  <= '0;
      s1_b5  <= '0;
      s1_b7  <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_idx <= in_idx;
        s1_neg <= in_neg;
        s1_b1  <= x_ext;
        s1_b3  <= b3_c;
        s1_b5  <= b5_c;
        s1_b7  <= b7_c;
      end
    end
  end

endmodule

// File: rtl/csd_pair_stage.sv
module csd_pair_stage
  import csd_pkg::*;
#(
  parameter int BW = 12,
  parameter int PW = 21
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   s1_vld,
  input  logic [IDXW-1:0]        s1_idx,
  input  logic                   s1_neg,
  input  logic signed [BW-1:0]   s1_b1,
  input  logic signed [BW-1:0]   s1_b3,
  input  logic signed [BW-1:0]   s1_b5,
  input  logic signed [BW-1:0]   s1_b7,
  output logic                   s2_vld,
  output logic signed [PW-1:0]   s2_pair,
  output logic signed [PW-1:0]   s2_rest
);

  logic signed [PW-1:0] term_v [NTERM];
  logic signed [PW-1:0] pair_c;

  function automatic logic signed [PW-1:0] shape_term(input term_t t, input logic flip);
    logic signed [BW-1:0] b;
    logic signed [PW-1:0] w;
    case (t.base)
      BASE_1:  b = s1_b1;
      BASE_3:  b = s1_b3;
      BASE_5:  b = s1_b5;
      default: b = s1_b7;
    endcase
    w = {{(PW-BW){b[BW-1]}}, b};
    w = w <<< t.sh;
    if (!t.used)            w = '0;
    else if (t.minus ^ flip) w = -w;
    return w;
  endfunction

  for (genvar g = 0; g < NTERM; g++) begin : g_term
    always_comb term_v[g] = shape_term(coef_term(s1_idx, g), s1_neg);
  end

  always_comb pair_c = term_v[0] + term_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld  <= 1'b0;
      s2_pair <= '0;
      s2_rest <= '0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_pair <= pair_c;
        s2_rest <= term_v[NTERM-1];
      end
    end
  end

endmodule

// File: rtl/csd_final_stage.sv
module csd_final_stage #(
  parameter int PW = 21
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   s2_vld,
  input  logic signed [PW-1:0]   s2_pair,
  input  logic signed [PW-1:0]   s2_rest,
  output logic                   out_vld,
  output logic signed [PW-1:0]   out_prod
);

  logic signed [PW-1:0] sum_c;
  always_comb sum_c = s2_pair + s2_rest;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_prod <= '0;
    end else begin
      out_vld <= s2_vld;
      if (s2_vld) out_prod <= sum_c;
    end
  end

  // R7: with no new result the product register keeps its value
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> $stable(out_prod));

endmodule

// File: rtl/csd_coef_mult.sv
module csd_coef_mult
  import csd_pkg::*;
#(
  parameter int XW = 9,
  localparam int BW = XW + 3,
  localparam int PW = XW + COEF_FRAC
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_vld,
  input  logic signed [XW-1:0]   in_x,
  input  logic [IDXW-1:0]        in_idx,
  input  logic                   in_neg,
  output logic                   out_vld,
  output logic signed [PW-1:0]   out_prod
);

  logic                  s1_vld, s1_neg, s2_vld;
  logic [IDXW-1:0]       s1_idx;
  logic signed [BW-1:0]  s1_b1, s1_b3, s1_b5, s1_b7;
  logic signed [PW-1:0]  s2_pair, s2_rest;

  csd_base_stage #(.XW(XW)) u_base (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(in_x), .in_idx(in_idx), .in_neg(in_neg),
    .s1_vld(s1_vld), .s1_idx(s1_idx), .s1_neg(s1_neg),
    .s1_b1(s1_b1), .s1_b3(s1_b3), .s1_b5(s1_b5), .s1_b7(s1_b7)
  );

  csd_pair_stage #(.BW(BW), .PW(PW)) u_pair (
    .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1_idx(s1_idx), .s1_neg(s1_neg),
    .s1_b1(s1_b1), .s1_b3(s1_b3), .s1_b5(s1_b5), .s1_b7(s1_b7),
    .s2_vld(s2_vld), .s2_pair(s2_pair), .s2_rest(s2_rest)
  );

  csd_final_stage #(.PW(PW)) u_final (
    .clk(clk), .rst(rst), .s2_vld(s2_vld), .s2_pair(s2_pair), .s2_rest(s2_rest),
    .out_vld(out_vld), .out_prod(out_prod)
  );

  localparam int MAXP = coef_value(3'd1) * (2 ** (XW - 1));

  // R5: an accepted operand produces a strobe exactly three cycles later
  a_r5_issue_to_result: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> ##3 out_vld);
  a_r5_result_has_issue: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(in_vld, 3));

  // R4: index 0 yields a zero product
  a_r4_zero_index: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(in_idx, 3) == '0) |-> (out_prod == '0));

  // R9: every result is inside the c1 magnitude bound
  a_r9_range: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (int'(out_prod) <= MAXP && int'(out_prod) >= -MAXP));

endmodule

// File: tb/tb_csd_coef_mult.sv
module tb_csd_coef_mult;

  localparam int XW = 9;
  localparam int PW = XW + 12;
  localparam int NV = 13;
  localparam int QD = 10000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [XW-1:0] in_x = '0;
  logic [2:0] in_idx = '0;
  logic in_neg = 1'b0;
  logic out_vld;
  logic signed [PW-1:0] out_prod;

  always #4 clk = ~clk;   // 125 MHz

  csd_coef_mult #(.XW(XW)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(in_x), .in_idx(in_idx), .in_neg(in_neg),
    .out_vld(out_vld), .out_prod(out_prod)
  );

  // R1 weights, index 0 = no weight
  localparam int COEF [8] = '{0, 2009, 1892, 1703, 1448, 1138, 784, 400};

  // Directed vectors: sample, index, sign, hand-worked product
  localparam int VX [NV] = '{   1,     -1,    255,   -256,    -256,    100,    -37, 12, 12, 0,    3,   -128,    77};
  localparam int VI [NV] = '{   1,      1,      4,      1,       1,      7,      3,  0,  0, 5,    6,      2,     5};
  localparam int VN [NV] = '{   0,      0,      0,      1,       0,      1,      0,  0,  1, 1,    0,      1,     0};
  localparam int VE [NV] = '{2009,  -2009, 369240, 514304, -514304, -40000, -63011,  0,  0, 0, 2352, 242176, 87626};

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wr = 0;
  int rd = 0;
  int exp_v [QD];
  int exp_c [QD];
  int exp_i [QD];
  int exp_n [QD];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_prod(input int x, input int idx, input int neg);
    return (neg != 0) ? -(x * COEF[idx]) : x * COEF[idx];
  endfunction

  function automatic string tag_of(input int idx, input int neg);
    if (idx == 0) return "R4";
    if (neg != 0) return "R3";
    return "R2";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // issue at a negedge; inputs are sampled by the next posedge
  task automatic issue(input int x, input int idx, input int neg, input int expv);
    in_vld = 1'b1;
    in_x   = XW'(x);
    in_idx = 3'(idx);
    in_neg = neg[0];
    exp_v[wr] = expv;
    exp_c[wr] = cyc;
    exp_i[wr] = idx;
    exp_n[wr] = neg;
    wr++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      in_vld = 1'b0;
      @(negedge clk);
    end
  endtask

  // scoreboard: outputs sampled at negedge, away from the active edge
  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (rd < wr) begin
        check(int'(out_prod) == exp_v[rd], tag_of(exp_i[rd], exp_n[rd]), int'(out_prod), exp_v[rd]);
        check(cyc - exp_c[rd] == 3, "R5", cyc - exp_c[rd], 3);
        rd++;
      end else begin
        check(1'b0, "R6", rd, wr);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic signed [PW-1:0] held;
    int n0;
    // R8: reset state
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0, "R8", int'(out_vld), 0);
    check(out_prod == '0, "R8", int'(out_prod), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_vld == 1'b0 && out_prod == '0, "R8", int'(out_prod), 0);

    // Directed vectors back to back: R1, R2, R3, R4, R9
    for (int v = 0; v < NV; v++) begin
      check(ref_prod(VX[v], VI[v], VN[v]) == VE[v], "R1", ref_prod(VX[v], VI[v], VN[v]), VE[v]);
      issue(VX[v], VI[v], VN[v], VE[v]);
    end
    idle(5);

    // Full sweep, one operand per cycle: R2, R3, R4, R6
    for (int idx = 0; idx < 8; idx++)
      for (int neg = 0; neg < 2; neg++)
        for (int x = -(1 << (XW - 1)); x < (1 << (XW - 1)); x++)
          issue(x, idx, neg, ref_prod(x, idx, neg));
    idle(5);
    check(rd == wr, "R6", rd, wr);

    // R7: inputs with strobe low leave the output alone
    held = out_prod;
    n0 = rd;
    for (int k = 0; k < 6; k++) begin
      in_vld = 1'b0;
      in_x   = XW'(k * 37 - 100);
      in_idx = 3'(k + 1);
      in_neg = k[0];
      @(negedge clk);
      check(out_prod == held && out_vld == 1'b0, "R7", int'(out_prod), int'(held));
    end
    check(rd == n0, "R7", rd, n0);

    // R8: reset mid-stream clears the output
    issue(200, 1, 0, 200 * 2009);
    rst = 1'b1;
    in_vld = 1'b0;
    wr--;
    repeat (2) @(negedge clk);
    check(out_vld == 1'b0 && out_prod == '0, "R8", int'(out_prod), 0);
    rst = 1'b0;
    idle(4);
    check(out_vld == 1'b0 && out_prod == '0, "R8", int'(out_prod), 0);

    finish_run();
  end

endmodule